// File: doc/BRIEF.md
# RV32I Control Word Decoder

This block is the purely combinational instruction decoder of a single-cycle RV32I core. It takes the 32-bit instruction word held in the fetch path and produces the control word that steers the datapath for that cycle: which immediate format the immediate builder should assemble, whether the destination register is written, where the two ALU operands come from, which ALU function is run, what kind of control transfer happens, whether write-back takes memory data, whether memory is written, and the width and signedness of the memory access.

It handles the 37 integer instructions of the base set. Environment calls, breakpoints, fences and status-register accesses are not decoded. Those opcodes, and every other opcode that is not recognised, fall into a quiet default that changes no architectural state. The immediate builder, register file, ALU, branch resolver and memories sit outside the block. They consume the control word in the same cycle.

Top module: `rv_ctrl_decoder`

## Requirements
- R1: Only instruction bits [6:2] (major opcode), [14:12] (funct3) and bit 30 affect any output. Changing any other bit, including bits [1:0], leaves the control word unchanged.
- R2: `imm_sel_o` is 000 for I-format, 001 for U, 010 for S, 011 for B and 100 for J. Register-register operations and unrecognised opcodes report 000.
- R3: `alu_a_pc_o` is 0 for rs1 and 1 for the PC. `alu_b_sel_o` is 00 for rs2, 01 for the immediate and 10 for the constant 4.
- R4: `alu_op_o` uses these codes: add 0000, sll 0001, slt 0010, sltu 0011, xor 0100, srl 0101, or 0110, and 0111, sub 1000, sra 1101, pass operand B 1111.
- R5: lui (opcode[6:2]=01101) selects U, operand B = immediate and pass-B, and writes rd. auipc (00101) selects U, A = PC, B = immediate and add, and writes rd.
- R6: jal (11011) and jalr (11001) both write rd with A = PC, B = 4 and add. jal uses J and branch type 001. jalr uses I and branch type 010. jalr ignores funct3.
- R7: A conditional branch (11000) selects B, A = rs1 and B = rs2, and writes no register. Its branch type and ALU op depend on funct3: beq 000 gives type 100 with sub; bne 001 gives type 101 with sub; blt 100 gives type 110 with slt; bge 101 gives type 111 with slt; bltu 110 gives type 110 with sltu; bgeu 111 gives type 111 with sltu.
- R8: A load (00000) selects I, A = rs1, B = immediate and add, sets `wb_mem_o` and writes rd.
- R9: A store (01000) selects S, A = rs1, B = immediate and add, sets `mem_wr_o` and writes no register.
- R10: `mem_fmt_o` equals funct3 for loads and stores (010 word, 001/101 half signed/unsigned, 000/100 byte signed/unsigned). For every other instruction it is 000.
- R11: For immediate operations (00100, B = immediate) and register operations (01100, B = rs2), funct3 selects add, sll, slt, sltu, xor, srl, or and. Bit 30 turns srl into sra for both groups, and turns add into sub only for register operations. Both groups write rd.
- R12: An unrecognised opcode, or a branch whose funct3 is 010 or 011, gives an all-zero control word: no register write, no memory write, branch type 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| imm_sel_o | output | 3 | Immediate format select |
| reg_wr_o | output | 1 | Destination register write enable |
| alu_a_pc_o | output | 1 | ALU operand A takes the PC |
| alu_b_sel_o | output | 2 | ALU operand B source |
| alu_op_o | output | 4 | ALU function code |
| branch_o | output | 3 | Control transfer type |
| wb_mem_o | output | 1 | Write-back takes memory read data |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_fmt_o | output | 3 | Memory access width and signedness |

## Verification
The assertions check cross-field consistency whenever the input is known. A store never also writes a register. A jump always forms its link address from the PC plus 4 and writes it. A conditional branch never writes and always compares against rs2. An unrecognised instruction stays quiet, and the memory format is zero outside loads and stores. None of this shows whether a given opcode lands in the right group, or whether a funct3 and bit-30 combination picks the right ALU code. The bench shows that by sweeping every opcode, funct3 and bit-30 combination with random filler in the unused bits, and by repeating fixed encodings with the filler flipped.

// File: rtl/rv_dec_pkg.sv
package rv_dec_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OPC_W   = 5;
  localparam int unsigned F3_W    = 3;
  localparam int unsigned OPC_LSB = 2;
  localparam int unsigned F3_LSB  = 12;
  localparam int unsigned ALT_BIT = 30;

  typedef enum logic [2:0] {
    IMM_I = 3'b000, IMM_U = 3'b001, IMM_S = 3'b010, IMM_B = 3'b011, IMM_J = 3'b100
  } imm_kind_e;

  typedef enum logic [1:0] {
    OPB_RS2 = 2'b00, OPB_IMM = 2'b01, OPB_FOUR = 2'b10
  } opb_sel_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'b0000, ALU_SLL = 4'b0001, ALU_SLT = 4'b0010, ALU_SLTU = 4'b0011,
    ALU_XOR  = 4'b0100, ALU_SRL = 4'b0101, ALU_OR  = 4'b0110, ALU_AND  = 4'b0111,
    ALU_SUB  = 4'b1000, ALU_SRA = 4'b1101, ALU_PASSB = 4'b1111
  } alu_fn_e;

  typedef enum logic [2:0] {
    BR_NONE = 3'b000, BR_JUMP_PC = 3'b001, BR_JUMP_REG = 3'b010,
    BR_EQ   = 3'b100, BR_NE = 3'b101, BR_LT = 3'b110, BR_GE = 3'b111
  } br_kind_e;

  typedef enum logic [3:0] {
    CL_LUI, CL_AUIPC, CL_JAL, CL_JALR, CL_BRANCH,
    CL_LOAD, CL_STORE, CL_OPIMM, CL_OP, CL_ILLEGAL
  } insn_class_e;

  typedef struct packed {
    imm_kind_e     imm;
    logic          reg_wr;
    logic          a_pc;
    opb_sel_e      opb;
    alu_fn_e       alu;
    br_kind_e      br;
    logic          wb_mem;
    logic          mem_wr;
    logic [F3_W-1:0] fmt;
  } ctrl_word_t;

  localparam ctrl_word_t CTRL_QUIET = '{
    imm: IMM_I, reg_wr: 1'b0, a_pc: 1'b0, opb: OPB_RS2, alu: ALU_ADD,
    br: BR_NONE, wb_mem: 1'b0, mem_wr: 1'b0, fmt: '0
  };
endpackage

// File: rtl/rv_opc_class.sv
module rv_opc_class
  import rv_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output insn_class_e      cls_o
);
  always_comb begin
    unique case (opc_i)
      5'b01101: cls_o = CL_LUI;
      5'b00101: cls_o = CL_AUIPC;
      5'b11011: cls_o = CL_JAL;
      5'b11001: cls_o = CL_JALR;
      5'b11000: cls_o = CL_BRANCH;
      5'b00000: cls_o = CL_LOAD;
      5'b01000: cls_o = CL_STORE;
      5'b00100: cls_o = CL_OPIMM;
      5'b01100: cls_o = CL_OP;
      default:  cls_o = CL_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/rv_alu_fn_sel.sv
module rv_alu_fn_sel
  import rv_dec_pkg::*;
(
  input  logic [F3_W-1:0] f3_i,
  input  logic            alt_i,
  input  logic            reg_form_i,
  output alu_fn_e         fn_o
);
  // sub only exists in register form; sra/srai in both
  logic sub_en;
  assign sub_en = alt_i & reg_form_i;

  always_comb begin
    unique case (f3_i)
      3'b000:  fn_o = sub_en ? ALU_SUB : ALU_ADD;
      3'b001:  fn_o = ALU_SLL;
      3'b010:  fn_o = ALU_SLT;
      3'b011:  fn_o = ALU_SLTU;
      3'b100:  fn_o = ALU_XOR;
      3'b101:  fn_o = alt_i ? ALU_SRA : ALU_SRL;
      3'b110:  fn_o = ALU_OR;
      default: fn_o = ALU_AND;
    endcase
  end
endmodule

// File: rtl/rv_branch_kind.sv
module rv_branch_kind
  import rv_dec_pkg::*;
(
  input  logic [F3_W-1:0] f3_i,
  output br_kind_e        br_o,
  output alu_fn_e         cmp_o,
  output logic            bad_o
);
  always_comb begin
    bad_o = 1'b0;
    unique case (f3_i)
      3'b000:  begin br_o = BR_EQ; cmp_o = ALU_SUB;  end
      3'b001:  begin br_o = BR_NE; cmp_o = ALU_SUB;  end
      3'b100:  begin br_o = BR_LT; cmp_o = ALU_SLT;  end
      3'b101:  begin br_o = BR_GE; cmp_o = ALU_SLT;  end
      3'b110:  begin br_o = BR_LT; cmp_o = ALU_SLTU; end
      3'b111:  begin br_o = BR_GE; cmp_o = ALU_SLTU; end
      default: begin br_o = BR_NONE; cmp_o = ALU_ADD; bad_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/rv_ctrl_decoder.sv
module rv_ctrl_decoder
  import rv_dec_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output logic [2:0]        imm_sel_o,
  output logic              reg_wr_o,
  output logic              alu_a_pc_o,
  output logic [1:0]        alu_b_sel_o,
  output logic [3:0]        alu_op_o,
  output logic [2:0]        branch_o,
  output logic              wb_mem_o,
  output logic              mem_wr_o,
  output logic [F3_W-1:0]   mem_fmt_o
);
  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic             alt;
  insn_class_e      cls;
  alu_fn_e          arith_fn, cmp_fn;
  br_kind_e         br_kind;
  logic             br_bad;
  ctrl_word_t       cw;

  assign opc = instr_i[OPC_LSB +: OPC_W];
  assign f3  = instr_i[F3_LSB +: F3_W];
  assign alt = instr_i[ALT_BIT];

  rv_opc_class u_class (.opc_i(opc), .cls_o(cls));

  rv_alu_fn_sel u_alu_fn (
    .f3_i(f3), .alt_i(alt), .reg_form_i(cls == CL_OP), .fn_o(arith_fn)
  );

  rv_branch_kind u_branch (
    .f3_i(f3), .br_o(br_kind), .cmp_o(cmp_fn), .bad_o(br_bad)
  );

  always_comb begin
    cw = CTRL_QUIET;
    unique case (cls)
      CL_LUI: begin
        cw.imm = IMM_U; cw.reg_wr = 1'b1; cw.opb = OPB_IMM; cw.alu = ALU_PASSB;
      end
      CL_AUIPC: begin
        cw.imm = IMM_U; cw.reg_wr = 1'b1; cw.a_pc = 1'b1; cw.opb = OPB_IMM;
      end
      CL_JAL: begin
        cw.imm = IMM_J; cw.reg_wr = 1'b1; cw.a_pc = 1'b1; cw.opb = OPB_FOUR;
        cw.br = BR_JUMP_PC;
      end
      CL_JALR: begin
        cw.imm = IMM_I; cw.reg_wr = 1'b1; cw.a_pc = 1'b1; cw.opb = OPB_FOUR;
        cw.br = BR_JUMP_REG;
      end
      CL_BRANCH: begin
        if (!br_bad) begin
          cw.imm = IMM_B; cw.alu = cmp_fn; cw.br = br_kind;
        end
      end
      CL_LOAD: begin
        cw.reg_wr = 1'b1; cw.opb = OPB_IMM; cw.wb_mem = 1'b1; cw.fmt = f3;
      end
      CL_STORE: begin
        cw.imm = IMM_S; cw.opb = OPB_IMM; cw.mem_wr = 1'b1; cw.fmt = f3;
      end
      CL_OPIMM: begin
        cw.reg_wr = 1'b1; cw.opb = OPB_IMM; cw.alu = arith_fn;
      end
      CL_OP: begin
        cw.reg_wr = 1'b1; cw.alu = arith_fn;
      end
      default: cw = CTRL_QUIET;
    endcase
  end

  assign imm_sel_o   = cw.imm;
  assign reg_wr_o    = cw.reg_wr;
  assign alu_a_pc_o  = cw.a_pc;
  assign alu_b_sel_o = cw.opb;
  assign alu_op_o    = cw.alu;
  assign branch_o    = cw.br;
  assign wb_mem_o    = cw.wb_mem;
  assign mem_wr_o    = cw.mem_wr;
  assign mem_fmt_o   = cw.fmt;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      assert_store_no_wb_R9: assert (!(mem_wr_o && reg_wr_o))
        else $error("store also writes rd");
      assert_link_srcs_R6: assert (!(branch_o == 3'b001 || branch_o == 3'b010) ||
                                   (alu_a_pc_o && alu_b_sel_o == 2'b10 && reg_wr_o))
        else $error("jump without PC+4 link");
      assert_branch_no_wb_R7: assert (!branch_o[2] ||
                                      (!reg_wr_o && alu_b_sel_o == 2'b00 && !alu_a_pc_o))
        else $error("conditional branch writes rd or bad sources");
      assert_illegal_quiet_R12: assert (cls != CL_ILLEGAL ||
                                        (!reg_wr_o && !mem_wr_o && branch_o == 3'b000))
        else $error("unrecognised opcode not quiet");
      assert_fmt_zero_R10: assert (mem_wr_o || wb_mem_o || mem_fmt_o == 3'b000)
        else $error("memory format outside load/store");
      assert_load_add_R8: assert (!wb_mem_o || (reg_wr_o && alu_op_o == 4'b0000))
        else $error("load without address add");
    end
  end
endmodule

// File: tb/rv_ctrl_decoder_test.sv
module rv_ctrl_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = 32'h0000_0013;
  logic [2:0]  imm_sel;
  logic        reg_wr, alu_a_pc, wb_mem, mem_wr;
  logic [1:0]  alu_b_sel;
  logic [3:0]  alu_op;
  logic [2:0]  branch, mem_fmt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit reported = 1'b0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rv_ctrl_decoder uut (
    .instr_i(instr), .imm_sel_o(imm_sel), .reg_wr_o(reg_wr), .alu_a_pc_o(alu_a_pc),
    .alu_b_sel_o(alu_b_sel), .alu_op_o(alu_op), .branch_o(branch),
    .wb_mem_o(wb_mem), .mem_wr_o(mem_wr), .mem_fmt_o(mem_fmt)
  );

  function automatic logic [3:0] arith(logic [2:0] f3, logic sub_ok, logic b30);
    case (f3)
      3'b000: return (sub_ok && b30) ? 4'b1000 : 4'b0000;
      3'b001: return 4'b0001;
      3'b010: return 4'b0010;
      3'b011: return 4'b0011;
      3'b100: return 4'b0100;
      3'b101: return b30 ? 4'b1101 : 4'b0101;
      3'b110: return 4'b0110;
      default: return 4'b0111;
    endcase
  endfunction

  // {imm, rw, apc, bsel, alu, br, wbm, mw, fmt}
  function automatic logic [18:0] model(logic [31:0] ins);
    logic [4:0] op = ins[6:2];
    logic [2:0] f3 = ins[14:12];
    logic b30 = ins[30];
    logic [2:0] imm = 0, br = 0, fmt = 0;
    logic rw = 0, apc = 0, wbm = 0, mw = 0;
    logic [1:0] bs = 0;
    logic [3:0] alu = 0;
    case (op)
      5'b01101: begin imm = 1; rw = 1; bs = 1; alu = 4'hF; end
      5'b00101: begin imm = 1; rw = 1; apc = 1; bs = 1; end
      5'b11011: begin imm = 4; rw = 1; apc = 1; bs = 2; br = 1; end
      5'b11001: begin rw = 1; apc = 1; bs = 2; br = 2; end
      5'b11000: begin
        case (f3)
          3'b000: begin imm = 3; br = 4; alu = 8; end
          3'b001: begin imm = 3; br = 5; alu = 8; end
          3'b100: begin imm = 3; br = 6; alu = 2; end
          3'b101: begin imm = 3; br = 7; alu = 2; end
          3'b110: begin imm = 3; br = 6; alu = 3; end
          3'b111: begin imm = 3; br = 7; alu = 3; end
          default: ;
        endcase
      end
      5'b00000: begin rw = 1; bs = 1; wbm = 1; fmt = f3; end
      5'b01000: begin imm = 2; bs = 1; mw = 1; fmt = f3; end
      5'b00100: begin rw = 1; bs = 1; alu = arith(f3, 1'b0, b30); end
      5'b01100: begin rw = 1; alu = arith(f3, 1'b1, b30); end
      default: ;
    endcase
    return {imm, rw, apc, bs, alu, br, wbm, mw, fmt};
  endfunction

  function automatic string tag_of(logic [4:0] op);
    case (op)
      5'b01101, 5'b00101: return "R5 R2 R3 R4";
      5'b11011, 5'b11001: return "R6 R2 R3";
      5'b11000: return "R7 R12 R2";
      5'b00000: return "R8 R10 R3";
      5'b01000: return "R9 R10 R2";
      5'b00100, 5'b01100: return "R11 R4 R3";
      default: return "R12 R10";
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [4:0] op, logic [2:0] f3, logic b30, logic [31:0] fill);
    logic [31:0] w = fill;
    w[6:2] = op;
    w[14:12] = f3;
    w[30] = b30;
    return w;
  endfunction

  task automatic drive(logic [31:0] w, logic [18:0] e, string t);
    @(posedge clk);
    instr = w;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // monitor: compare half a cycle after the driver
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [18:0] act;
      logic [18:0] e;
      string t;
      act = {imm_sel, reg_wr, alu_a_pc, alu_b_sel, alu_op, branch, wb_mem, mem_wr, mem_fmt};
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s instr=%h actual=%b expected=%b", t, instr, act, e);
      end
    end
  end

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle nop after reset: addi x0,x0,0 => R11 immediate add, writes rd
    drive(32'h0000_0013, {3'b000, 1'b1, 1'b0, 2'b01, 4'b0000, 3'b000, 1'b0, 1'b0, 3'b000}, "R11 reset nop");
    // R1: same fields, filler all-zero vs all-one, including bits [1:0]
    drive(mk(5'b01000, 3'b001, 1'b0, 32'h0000_0000), model(mk(5'b01000, 3'b001, 1'b0, 0)), "R1 store zero fill");
    drive(mk(5'b01000, 3'b001, 1'b0, 32'hFFFF_FFFF), model(mk(5'b01000, 3'b001, 1'b0, 0)), "R1 store one fill");
    drive(mk(5'b01101, 3'b111, 1'b1, 32'hA5A5_5A5A), model(mk(5'b01101, 3'b000, 1'b0, 0)), "R1 lui ignores f3/b30");
    drive(mk(5'b11001, 3'b101, 1'b0, 32'h1234_5678), model(mk(5'b11001, 3'b000, 1'b0, 0)), "R1 R6 jalr ignores funct3");
    // R11 corner: addi with bit30 set stays add; add with bit30 is sub
    drive(mk(5'b00100, 3'b000, 1'b1, 0), {3'b000, 1'b1, 1'b0, 2'b01, 4'b0000, 3'b000, 1'b0, 1'b0, 3'b000}, "R11 addi b30");
    drive(mk(5'b01100, 3'b000, 1'b1, 0), {3'b000, 1'b1, 1'b0, 2'b00, 4'b1000, 3'b000, 1'b0, 1'b0, 3'b000}, "R11 R4 sub");
    drive(mk(5'b00100, 3'b101, 1'b1, 0), {3'b000, 1'b1, 1'b0, 2'b01, 4'b1101, 3'b000, 1'b0, 1'b0, 3'b000}, "R11 R4 srai");
    // R12: illegal branch funct3 and system opcode are quiet
    drive(mk(5'b11000, 3'b010, 1'b0, 0), 19'd0, "R12 branch f3=010");
    drive(mk(5'b11100, 3'b000, 1'b0, 0), 19'd0, "R12 system opcode");
    // R10: lhu format
    drive(mk(5'b00000, 3'b101, 1'b0, 0), {3'b000, 1'b1, 1'b0, 2'b01, 4'b0000, 3'b000, 1'b1, 1'b0, 3'b101}, "R8 R10 lhu");
    // R7: bltu
    drive(mk(5'b11000, 3'b110, 1'b0, 0), {3'b011, 1'b0, 1'b0, 2'b00, 4'b0011, 3'b110, 1'b0, 1'b0, 3'b000}, "R7 bltu");
    // full sweep with random filler
    for (int op = 0; op < 32; op++)
      for (int f = 0; f < 8; f++)
        for (int b = 0; b < 2; b++) begin
          logic [31:0] w;
          w = mk(op[4:0], f[2:0], b[0], $urandom());
          drive(w, model(w), tag_of(op[4:0]));
        end
    @(posedge clk);
    while (exp_q.size() > 0) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule